// File: doc/BRIEF.md
# Prescaled PWM Timer with Staged Reload

This block is a single-channel pulse-width modulation timer with a two-word register port. A power-of-two prescaler turns the input clock into counter ticks, a 10-bit period counter counts those ticks, and the output is high for the first part of every period. The length of that high part is set by a 10-bit high-time value. Software programs the period, the high time and the prescaler exponent through a simple synchronous write port, and reads them back through a combinational read port.

Changing the period, the high time and the prescaler one at a time could leave the output running with a mix of old and new values. To avoid this, a staging bit in the control word diverts those writes into shadow copies. When software clears the staging bit, the shadow copies move into the active set in a single cycle, and the counter and the prescaler restart from zero. Settings that the counter cannot use are refused: an enable request is refused while the period or the high time is zero, and a zero field written while the output runs is dropped. Each refusal sets a readable flag.

Top module: `shadowed_pwm_timer`

## Requirements
- R1: After reset, and while reset is held, `pwm_out` is 0 and both registers read 0.
- R2: The control word is at byte offset 0x00. Its fields are: bit 0 = run enable, bit 11 = staging, bit 15 = exponent LSB, bits 19:16 = exponent >> 1, bit 31 = refusal flag (read-only). The count word is at offset 0x04, with the period at bits 25:16 and the high time at bits 9:0. Unused bits and any other offset read as 0.
- R3: One counter tick lasts 2^E input clocks, where E = {ctrl[19:16], ctrl[15]} ranges from 0 to 24.
- R4: A control write whose exponent exceeds 24 leaves the stored exponent unchanged. The other fields of that write still take effect.
- R5: While running, the counter starts at 0 and wraps to 0 after reaching period−1. The output is high while the count is below the high time. A high time at or above the period gives a constant high.
- R6: While run enable is 0, the output is low and the counter and prescaler are held at zero. Re-enabling starts a fresh period, with the output high in the first cycle.
- R7: An enable request is refused while the period or the high time is zero, counting both the staged values and the values that will be active. A refused request leaves run enable at 0 and sets bit 31. Any accepted control write clears bit 31.
- R8: While running, a count write with a zero period or a zero high time is dropped entirely and sets bit 31.
- R9: While staging is 1, count writes and exponent writes change only the readable (staged) values. The output keeps running with the old active settings.
- R10: A control write that clears a set staging bit copies the period, the high time and the exponent into the active set in the same cycle, and restarts the counter and the prescaler from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | ADDR_W (3) | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pwm_out | output | 1 | PWM output |

## Verification
The main function is driven with three patterns:
- Period 5 and high time 2 at exponent 0 gives a 2-of-5 waveform. This separates an off-by-one in the wrap from one in the compare.
- The same setting at exponent 2 checks that every tick stretches by exactly four clocks.
- A high time above the period must give an output that never drops, which exposes a compare done against the period.

A staged update is started while the output runs. During staging the bench confirms that the waveform keeps its old shape while the read-back already shows the new values. After release, the first cycles of the new period tell an immediate restart apart from finishing the old period. A reference model in the bench follows every register and the counter on each clock, so refused enables and dropped count writes are compared as well as the waveform.

// File: rtl/pwmt_pkg.sv
`timescale 1ns/1ps
package pwmt_pkg;
  localparam int DATA_W  = 32;
  localparam int CNT_W   = 10;
  localparam int MAX_EXP = 24;
  localparam int EXP_W   = $clog2(MAX_EXP + 1);
  localparam int PRE_W   = MAX_EXP;

  localparam int OFF_CTRL = 0;
  localparam int OFF_CNT  = 4;

  localparam int EN_BIT   = 0;
  localparam int SYNC_BIT = 11;
  localparam int ELSB_BIT = 15;
  localparam int EHI_LO   = 16;
  localparam int EHI_W    = EXP_W - 1;
  localparam int BLK_BIT  = 31;
  localparam int CYC_LO   = 16;
  localparam int PH_LO    = 0;

  // Exponent from a control word: high part in a 4-bit field, LSB apart
  function automatic logic [EXP_W-1:0] f_exp_field(input logic [DATA_W-1:0] w);
    return {w[EHI_LO +: EHI_W], w[ELSB_BIT]};
  endfunction

  // Low-bit mask whose all-ones state marks the last clock of a tick
  function automatic logic [PRE_W-1:0] f_tick_mask(input logic [EXP_W-1:0] e);
    logic [PRE_W:0] one_hot;
    one_hot = (PRE_W+1)'(1) << e;
    return one_hot[PRE_W-1:0] - PRE_W'(1);
  endfunction

  // Next count value with wrap after period-1
  function automatic logic [CNT_W-1:0] f_wrap_next(input logic [CNT_W-1:0] c,
                                                   input logic [CNT_W-1:0] cyc);
    logic [CNT_W:0] inc;
    inc = {1'b0, c} + (CNT_W+1)'(1);
    return (inc >= {1'b0, cyc}) ? '0 : inc[CNT_W-1:0];
  endfunction

  function automatic logic [DATA_W-1:0] f_ctrl_word(input logic blk,
                                                    input logic [EXP_W-1:0] e,
                                                    input logic sync,
                                                    input logic en);
    logic [DATA_W-1:0] w;
    w = '0;
    w[BLK_BIT]            = blk;
    w[EHI_LO +: EHI_W]    = e[EXP_W-1:1];
    w[ELSB_BIT]           = e[0];
    w[SYNC_BIT]           = sync;
    w[EN_BIT]             = en;
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] f_cnt_word(input logic [CNT_W-1:0] cyc,
                                                   input logic [CNT_W-1:0] ph);
    logic [DATA_W-1:0] w;
    w = '0;
    w[CYC_LO +: CNT_W] = cyc;
    w[PH_LO +: CNT_W]  = ph;
    return w;
  endfunction
endpackage

// File: rtl/pwmt_regs.sv
`timescale 1ns/1ps
module pwmt_regs
  import pwmt_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              run_en,
  output logic              sync_q,
  output logic [CNT_W-1:0]  act_cyc,
  output logic [CNT_W-1:0]  act_ph,
  output logic [EXP_W-1:0]  act_exp,
  output logic              restart,
  output logic              reject_en,
  output logic              drop_cnt
);
  logic [CNT_W-1:0] sh_cyc, sh_ph;
  logic [EXP_W-1:0] sh_exp, sh_exp_nx, w_exp;
  logic [CNT_W-1:0] w_cyc, w_ph, nx_act_cyc, nx_act_ph;
  logic             blocked, ctrl_wr, cnt_wr, w_sync, w_en, exp_ok, en_ok;
  logic             unused_wbits;

  assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(OFF_CTRL));
  assign cnt_wr  = bus_wr && (bus_addr == ADDR_W'(OFF_CNT));

  assign w_sync = bus_wdata[SYNC_BIT];
  assign w_en   = bus_wdata[EN_BIT];
  assign w_exp  = f_exp_field(bus_wdata);
  assign w_cyc  = bus_wdata[CYC_LO +: CNT_W];
  assign w_ph   = bus_wdata[PH_LO +: CNT_W];
  assign unused_wbits = ^{bus_wdata[31:26], bus_wdata[14:12], bus_wdata[10]};

  assign exp_ok    = (w_exp <= EXP_W'(MAX_EXP));
  assign sh_exp_nx = exp_ok ? w_exp : sh_exp;

  // Active values after this control write: staged set moves in when staging ends
  assign nx_act_cyc = w_sync ? act_cyc : sh_cyc;
  assign nx_act_ph  = w_sync ? act_ph  : sh_ph;

  assign en_ok = (sh_cyc != '0) && (sh_ph != '0) &&
                 (nx_act_cyc != '0) && (nx_act_ph != '0);

  assign restart   = ctrl_wr && sync_q && !w_sync;
  assign reject_en = ctrl_wr && w_en && !en_ok;
  assign drop_cnt  = cnt_wr && run_en && ((w_cyc == '0) || (w_ph == '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_en  <= 1'b0;
      sync_q  <= 1'b0;
      blocked <= 1'b0;
      sh_cyc  <= '0;
      sh_ph   <= '0;
      sh_exp  <= '0;
      act_cyc <= '0;
      act_ph  <= '0;
      act_exp <= '0;
    end else if (ctrl_wr) begin
      sync_q  <= w_sync;
      run_en  <= w_en && en_ok;
      blocked <= reject_en;
      sh_exp  <= sh_exp_nx;
      if (!w_sync) begin
        act_exp <= sh_exp_nx;
        act_cyc <= sh_cyc;
        act_ph  <= sh_ph;
      end
    end else if (cnt_wr) begin
      if (drop_cnt) begin
        blocked <= 1'b1;
      end else begin
        sh_cyc <= w_cyc;
        sh_ph  <= w_ph;
        if (!sync_q) begin
          act_cyc <= w_cyc;
          act_ph  <= w_ph;
        end
      end
    end
  end

  always_comb begin
    if (bus_addr == ADDR_W'(OFF_CTRL))
      bus_rdata = f_ctrl_word(blocked, sh_exp, sync_q, run_en);
    else if (bus_addr == ADDR_W'(OFF_CNT))
      bus_rdata = f_cnt_word(sh_cyc, sh_ph);
    else
      bus_rdata = '0;
  end
endmodule

// File: rtl/pwmt_prescaler.sv
`timescale 1ns/1ps
module pwmt_prescaler
  import pwmt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clear,
  input  logic [EXP_W-1:0] exp_sel,
  output logic             tick,
  output logic [PRE_W-1:0] pre_cnt
);
  logic [PRE_W-1:0] mask;

  assign mask = f_tick_mask(exp_sel);
  assign tick = run && ((pre_cnt & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pre_cnt <= '0;
    else if (!run || clear)  pre_cnt <= '0;
    else                     pre_cnt <= pre_cnt + PRE_W'(1);
  end
endmodule

// File: rtl/pwmt_counter.sv
`timescale 1ns/1ps
module pwmt_counter
  import pwmt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clear,
  input  logic             tick,
  input  logic [CNT_W-1:0] cyc,
  input  logic [CNT_W-1:0] ph,
  output logic [CNT_W-1:0] cnt,
  output logic             pwm_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!run || clear)  cnt <= '0;
    else if (tick)           cnt <= f_wrap_next(cnt, cyc);
  end

  assign pwm_out = run && (cnt < ph);
endmodule

// File: rtl/shadowed_pwm_timer.sv
`timescale 1ns/1ps
module shadowed_pwm_timer
  import pwmt_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              pwm_out
);
  logic             run_en, sync_q, restart, tick, reject_en, drop_cnt;
  logic [CNT_W-1:0] act_cyc, act_ph, cnt;
  logic [EXP_W-1:0] act_exp;
  logic [PRE_W-1:0] pre_cnt;

  pwmt_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .run_en(run_en),
    .sync_q(sync_q), .act_cyc(act_cyc), .act_ph(act_ph), .act_exp(act_exp),
    .restart(restart), .reject_en(reject_en), .drop_cnt(drop_cnt)
  );

  pwmt_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .run(run_en), .clear(restart),
    .exp_sel(act_exp), .tick(tick), .pre_cnt(pre_cnt)
  );

  pwmt_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run_en), .clear(restart), .tick(tick),
    .cyc(act_cyc), .ph(act_ph), .cnt(cnt), .pwm_out(pwm_out)
  );
endmodule

// File: rtl/pwmt_checker.sv
`timescale 1ns/1ps
module pwmt_checker
  import pwmt_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             run_en,
  input logic             sync_q,
  input logic             restart,
  input logic             tick,
  input logic             reject_en,
  input logic             drop_cnt,
  input logic [CNT_W-1:0] cnt,
  input logic [PRE_W-1:0] pre_cnt,
  input logic [CNT_W-1:0] act_cyc,
  input logic [CNT_W-1:0] act_ph,
  input logic [EXP_W-1:0] act_exp,
  input logic             pwm_out
);
  a_r6_off_low: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |-> !pwm_out);

  a_r7_run_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    run_en |-> (act_cyc != '0 && act_ph != '0));

  a_r7_reject_no_run: assert property (@(posedge clk) disable iff (!rst_n)
    reject_en |=> !run_en);

  a_r8_drop_keeps_active: assert property (@(posedge clk) disable iff (!rst_n)
    drop_cnt |=> ($stable(act_cyc) && $stable(act_ph)));

  a_r6_idle_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (cnt == '0 && pre_cnt == '0));

  a_r10_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0 && pre_cnt == '0));

  a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && tick && !restart) |=> (cnt == $past(cnt) + 1'b1 || cnt == '0));

  a_r5_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !tick && !restart) |=> $stable(cnt));

  a_r9_active_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_q && !restart) |=> ($stable(act_cyc) && $stable(act_ph) && $stable(act_exp)));
endmodule

bind shadowed_pwm_timer pwmt_checker u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .sync_q(sync_q),
  .restart(restart), .tick(tick), .reject_en(reject_en), .drop_cnt(drop_cnt),
  .cnt(cnt), .pre_cnt(pre_cnt), .act_cyc(act_cyc), .act_ph(act_ph),
  .act_exp(act_exp), .pwm_out(pwm_out)
);

// File: tb/sim_shadowed_pwm_timer.sv
`timescale 1ns/1ps
module sim_shadowed_pwm_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        pwm_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  string phase_req = "R1";

  always #10 clk = ~clk;

  shadowed_pwm_timer u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  // Behavioural reference state
  int m_en, m_sync, m_blk, m_sh_cyc, m_sh_ph, m_sh_exp;
  int m_cyc, m_ph, m_exp, m_cnt, m_pre;

  function automatic logic [31:0] model_read(input logic [2:0] a);
    logic [31:0] r;
    r = 32'd0;
    if (a == 3'd0) begin
      r[31] = m_blk[0];
      r[19:16] = 4'(m_sh_exp / 2);
      r[15] = m_sh_exp[0];
      r[11] = m_sync[0];
      r[0] = m_en[0];
    end else if (a == 3'd4) begin
      r[25:16] = 10'(m_sh_cyc);
      r[9:0] = 10'(m_sh_ph);
    end
    return r;
  endfunction

  task automatic model_step();
    int span, e, c, p, ncyc, nph;
    bit tk, rs, ok;
    if (!rst_n) begin
      m_en = 0; m_sync = 0; m_blk = 0; m_sh_cyc = 0; m_sh_ph = 0; m_sh_exp = 0;
      m_cyc = 0; m_ph = 0; m_exp = 0; m_cnt = 0; m_pre = 0;
      return;
    end
    span = 1 << m_exp;
    tk = (m_en != 0) && ((m_pre % span) == span - 1);
    rs = bus_wr && bus_addr == 3'd0 && m_sync != 0 && !bus_wdata[11];
    if (m_en == 0 || rs) begin
      m_cnt = 0; m_pre = 0;
    end else begin
      m_pre = (m_pre + 1) % (1 << 24);
      if (tk) m_cnt = (m_cnt + 1 >= m_cyc) ? 0 : m_cnt + 1;
    end
    if (bus_wr && bus_addr == 3'd0) begin
      e = int'({bus_wdata[19:16], bus_wdata[15]});
      if (e <= 24) m_sh_exp = e;
      ncyc = bus_wdata[11] ? m_cyc : m_sh_cyc;
      nph  = bus_wdata[11] ? m_ph  : m_sh_ph;
      ok = m_sh_cyc != 0 && m_sh_ph != 0 && ncyc != 0 && nph != 0;
      m_blk = (bus_wdata[0] && !ok) ? 1 : 0;
      m_en = (bus_wdata[0] && ok) ? 1 : 0;
      m_sync = bus_wdata[11] ? 1 : 0;
      if (!bus_wdata[11]) begin
        m_cyc = m_sh_cyc; m_ph = m_sh_ph; m_exp = m_sh_exp;
      end
    end else if (bus_wr && bus_addr == 3'd4) begin
      c = int'(bus_wdata[25:16]);
      p = int'(bus_wdata[9:0]);
      if (m_en != 0 && (c == 0 || p == 0)) m_blk = 1;
      else begin
        m_sh_cyc = c; m_sh_ph = p;
        if (m_sync == 0) begin m_cyc = c; m_ph = p; end
      end
    end
  endtask

  // Reference model advanced on every edge, compared a quarter period later
  always @(posedge clk) begin
    logic exp_out;
    logic [31:0] exp_rd;
    model_step();
    #5;
    if (!done) begin
      exp_out = (m_en != 0) && (m_cnt < m_ph);
      exp_rd = model_read(bus_addr);
      n_cmp++;
      if (pwm_out !== exp_out || bus_rdata !== exp_rd) begin
        n_bad++;
        $display("FAIL %s model: pwm_out=%0b rdata=%h expected pwm_out=%0b rdata=%h",
                 phase_req, pwm_out, bus_rdata, exp_out, exp_rd);
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp_v);
    n_cmp++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [31:0] exp_v);
    @(negedge clk);
    bus_addr = a;
    #2;
    chk(req, bus_rdata, exp_v);
  endtask

  // Counts high samples, one per cycle, starting with the current cycle
  task automatic count_high(input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      #1;
      if (pwm_out === 1'b1) hi++;
      @(negedge clk);
    end
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int hi;
    repeat (3) @(negedge clk);
    // R1: reset state
    phase_req = "R1";
    #2;
    chk("R1 pwm_out in reset", 32'(pwm_out), 32'd0);
    bus_addr = 3'd4; #1;
    chk("R1 count word in reset", bus_rdata, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2: layout and unused bits
    phase_req = "R2";
    wr(3'd4, 32'h0004_0001);
    rd_chk("R2 count readback", 3'd4, 32'h0004_0001);
    wr(3'd0, 32'h0001_8000);
    rd_chk("R2 ctrl readback exp=3", 3'd0, 32'h0001_8000);
    rd_chk("R2 unmapped offset", 3'd2, 32'd0);
    wr(3'd4, 32'hFFFF_FFFF);
    rd_chk("R2 unused count bits zero", 3'd4, 32'h03FF_03FF);

    // R4: out-of-range exponent keeps the old one
    phase_req = "R4";
    wr(3'd0, 32'h000C_8000);
    rd_chk("R4 exponent 25 ignored", 3'd0, 32'h0001_8000);

    // R7: enable refused with zero high time
    phase_req = "R7";
    wr(3'd4, 32'h0005_0000);
    wr(3'd0, 32'h0000_0001);
    rd_chk("R7 refused enable sets bit31", 3'd0, 32'h8000_0000);
    count_high(5, hi);
    chk("R7 output low after refusal", 32'(hi), 32'd0);

    // R5: period 5, high time 2, exponent 0
    phase_req = "R5";
    wr(3'd4, 32'h0005_0002);
    wr(3'd0, 32'h0000_0001);
    #1;
    chk("R5 first cycle high", 32'(pwm_out), 32'd1);
    count_high(10, hi);
    chk("R5 2-of-5 over two periods", 32'(hi), 32'd4);
    rd_chk("R7 accepted enable clears bit31", 3'd0, 32'h0000_0001);

    // R3: exponent 2 stretches ticks to 4 clocks
    phase_req = "R3";
    wr(3'd0, 32'h0001_0000);
    wr(3'd0, 32'h0001_0001);
    count_high(8, hi);
    chk("R3 high for 2 ticks of 4 clocks", 32'(hi), 32'd8);
    count_high(12, hi);
    chk("R3 low for 3 ticks of 4 clocks", 32'(hi), 32'd0);

    // R9: staged update keeps the old waveform
    phase_req = "R9";
    wr(3'd0, 32'h0001_0801);
    wr(3'd4, 32'h0004_0003);
    rd_chk("R9 staged count visible", 3'd4, 32'h0004_0003);
    rd_chk("R9 staging bit visible", 3'd0, 32'h0001_0801);
    count_high(20, hi);
    chk("R9 old waveform kept while staged", 32'(hi), 32'd8);

    // R10: release copies all settings and restarts
    phase_req = "R10";
    wr(3'd0, 32'h0000_0001);
    count_high(3, hi);
    chk("R10 restart: first three cycles high", 32'(hi), 32'd3);
    count_high(1, hi);
    chk("R10 fourth cycle low", 32'(hi), 32'd0);
    count_high(8, hi);
    chk("R10 new 3-of-4 waveform", 32'(hi), 32'd6);

    // R8: zero period while running is dropped
    phase_req = "R8";
    wr(3'd4, 32'h0000_0003);
    rd_chk("R8 count unchanged after drop", 3'd4, 32'h0004_0003);
    rd_chk("R8 drop sets bit31", 3'd0, 32'h8000_0001);
    count_high(8, hi);
    chk("R8 waveform unchanged after drop", 32'(hi), 32'd6);

    // R5: high time above period gives constant high
    phase_req = "R5";
    wr(3'd4, 32'h0003_0007);
    count_high(20, hi);
    chk("R5 constant high when high time >= period", 32'(hi), 32'd20);

    // R6: disable holds low, re-enable starts fresh
    phase_req = "R6";
    wr(3'd0, 32'h0000_0000);
    count_high(10, hi);
    chk("R6 output low while disabled", 32'(hi), 32'd0);
    rd_chk("R6 ctrl after disable", 3'd0, 32'h0000_0000);
    wr(3'd0, 32'h0000_0001);
    #1;
    chk("R6 re-enable first cycle high", 32'(pwm_out), 32'd1);
    count_high(10, hi);

    // R1: reset while running
    phase_req = "R1";
    @(negedge clk);
    rst_n = 1'b0;
    bus_addr = 3'd0;
    #2;
    chk("R1 pwm_out low on reset", 32'(pwm_out), 32'd0);
    chk("R1 ctrl word cleared", bus_rdata, 32'd0);
    bus_addr = 3'd4;
    #1;
    chk("R1 count word cleared", bus_rdata, 32'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule